// File: doc/BRIEF.md
# Integer ALU with Compare

This block is the execute-stage arithmetic-logic unit of a small load/store processor core. Each cycle it takes two 32-bit register operands, a 5-bit shift count and a 16-bit immediate, and an operation code. It returns a 32-bit result and a flag that is set when that result is all zeros. The branch logic uses that flag to resolve equal and not-equal branches.

The unit covers these operations:

- add and subtract, which wrap silently;
- AND, OR and NOR, where NOR with a zero operand gives bitwise NOT;
- logical left and right shifts;
- signed and unsigned set-less-than;
- load-upper-immediate.

The immediate forms extend their constant inside the block before use. Add-immediate and the compare-immediates replicate bit 15. The logical immediates pad with zeros.

The compares share the subtractor. The unsigned compare lets one operation check that an index lies between 0 and a bound, because a negative index reads as a very large unsigned value. By default the result and flag go through one register stage. That stage can be removed by parameter.

Top module: `int_alu`

## Requirements
- R1: Code 0 gives opa+opb and code 1 gives opa−opb, both modulo 2^32 with no overflow indication.
- R2: Code 2 gives opa AND opb, code 3 gives opa OR opb, and code 4 gives NOT(opa OR opb). Code 4 with opb = 0 returns the bitwise inverse of opa.
- R3: Code 9 (add-immediate) gives opa plus the immediate sign-extended by replicating bit 15. An immediate of 0xFFFF therefore subtracts one.
- R4: Code 7 compares opa with opb, and code 10 compares opa with the sign-extended immediate. Both compares are signed two's complement and return 1 in bit 0 when opa is the smaller, otherwise 0. The upper 31 bits are always 0.
- R5: Code 8 compares opa with opb, and code 11 compares opa with the sign-extended immediate. Both compares are unsigned and return 1 or 0 as in R4. With opa=0xFFFFFFFF and opb=0 the result is 0.
- R6: Code 5 shifts opb left and code 6 shifts it right, by shamt positions. Vacated bits are filled with 0 and opa has no effect.
- R7: Code 14 places the immediate in bits 31:16 and clears bits 15:0. Neither operand affects the result.
- R8: Code 12 gives opa AND the zero-extended immediate, and code 13 gives opa OR the zero-extended immediate.
- R9: zero_o is 1 exactly when res_o is all zeros.
- R10: Code 15 is undefined and gives res_o = 0 with zero_o = 1, whatever the operands are.
- R11: With the output register present, res_o and zero_o follow the inputs sampled at the previous rising clock edge. While reset is low they read 0 and 1 respectively.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock for the output register |
| rst_ni | input | 1 | Asynchronous reset, active low |
| op_i | input | 4 | Operation code (see requirements) |
| opa_i | input | 32 | First register operand |
| opb_i | input | 32 | Second register operand; the shifted value |
| shamt_i | input | 5 | Shift count |
| imm_i | input | 16 | Immediate constant |
| res_o | output | 32 | Result |
| zero_o | output | 1 | Result-is-zero flag |

## Verification
The hardest cases to reach are those where the signed and unsigned compares must disagree. In these cases the subtractor's difference overflows, or the operands straddle the sign boundary: all-ones against zero, and the largest positive value against the most negative. The stimulus drives those operand pairs directly into both register compares. It also sends a 0xFFFF immediate through the compare-immediate path, so that sign extension meets an unsigned compare. A further case holds new inputs for part of a cycle and samples before the edge, which shows that the result waits for the register.

// File: rtl/int_alu_pkg.sv
package int_alu_pkg;

    typedef enum logic [3:0] {
        OP_ADD   = 4'd0,
        OP_SUB   = 4'd1,
        OP_AND   = 4'd2,
        OP_OR    = 4'd3,
        OP_NOR   = 4'd4,
        OP_SLL   = 4'd5,
        OP_SRL   = 4'd6,
        OP_SLT   = 4'd7,
        OP_SLTU  = 4'd8,
        OP_ADDI  = 4'd9,
        OP_SLTI  = 4'd10,
        OP_SLTIU = 4'd11,
        OP_ANDI  = 4'd12,
        OP_ORI   = 4'd13,
        OP_LUI   = 4'd14,
        OP_RSV   = 4'd15
    } alu_op_e;

    // Operations that run the shared adder in subtract mode
    function automatic logic needs_sub(alu_op_e op);
        return (op == OP_SUB) || (op == OP_SLT) || (op == OP_SLTU) ||
               (op == OP_SLTI) || (op == OP_SLTIU);
    endfunction

endpackage

// File: rtl/alu_opnd.sv
module alu_opnd
    import int_alu_pkg::*;
#(
    parameter int DW   = 32,
    parameter int IMMW = 16
) (
    input  alu_op_e          op,
    input  logic [DW-1:0]    opb,
    input  logic [IMMW-1:0]  imm,
    output logic [DW-1:0]    opnd
);
    localparam int PADW = DW - IMMW;

    logic [DW-1:0] sext_imm;
    logic [DW-1:0] zext_imm;

    always_comb begin
        sext_imm = {{PADW{imm[IMMW-1]}}, imm};
        zext_imm = {{PADW{1'b0}}, imm};
        unique case (op)
            OP_ADDI, OP_SLTI, OP_SLTIU: opnd = sext_imm;
            OP_ANDI, OP_ORI:            opnd = zext_imm;
            default:                    opnd = opb;
        endcase
    end

endmodule

// File: rtl/alu_arith.sv
module alu_arith #(
    parameter int DW = 32
) (
    input  logic [DW-1:0] a,
    input  logic [DW-1:0] b,
    input  logic          sub_en,
    output logic [DW-1:0] sum,
    output logic          lt_s,
    output logic          lt_u
);
    localparam int MSB = DW - 1;

    logic [DW-1:0] b_eff;
    logic [DW:0]   full;
    logic          carry;
    logic          ovf;

    always_comb begin
        b_eff = sub_en ? ~b : b;
        full  = {1'b0, a} + {1'b0, b_eff} + {{DW{1'b0}}, sub_en};
        sum   = full[DW-1:0];
        carry = full[DW];
        // overflow of a - b: operand signs differ and the sign of the difference
        // differs from a
        ovf   = (a[MSB] ^ b[MSB]) & (a[MSB] ^ sum[MSB]);
        lt_s  = sum[MSB] ^ ovf;
        lt_u  = ~carry;
    end

endmodule

// File: rtl/alu_bitlog.sv
module alu_bitlog
    import int_alu_pkg::*;
#(
    parameter int DW   = 32,
    parameter int IMMW = 16,
    parameter int SHW  = 5
) (
    input  alu_op_e          op,
    input  logic [DW-1:0]    a,
    input  logic [DW-1:0]    b,
    input  logic [SHW-1:0]   shamt,
    input  logic [IMMW-1:0]  imm,
    output logic [DW-1:0]    res
);
    localparam int LOW = DW - IMMW;

    always_comb begin
        unique case (op)
            OP_AND, OP_ANDI: res = a & b;
            OP_OR,  OP_ORI:  res = a | b;
            OP_NOR:          res = ~(a | b);
            OP_SLL:          res = b << shamt;
            OP_SRL:          res = b >> shamt;
            OP_LUI:          res = {imm, {LOW{1'b0}}};
            default:         res = '0;
        endcase
    end

endmodule

// File: rtl/int_alu.sv
module int_alu
    import int_alu_pkg::*;
#(
    parameter int DW      = 32,
    parameter int IMMW    = 16,
    parameter bit REG_OUT = 1'b1
) (
    input  logic                    clk_i,
    input  logic                    rst_ni,
    input  logic [3:0]              op_i,
    input  logic [DW-1:0]           opa_i,
    input  logic [DW-1:0]           opb_i,
    input  logic [$clog2(DW)-1:0]   shamt_i,
    input  logic [IMMW-1:0]         imm_i,
    output logic [DW-1:0]           res_o,
    output logic                    zero_o
);
    localparam int SHW = $clog2(DW);

    typedef struct packed {
        logic [DW-1:0] res;
        logic          zero;
    } alu_out_t;

    alu_op_e       op_e;
    logic [DW-1:0] opnd2;
    logic [DW-1:0] sum_w;
    logic          lt_s_w;
    logic          lt_u_w;
    logic [DW-1:0] bl_w;
    logic          sub_w;
    alu_out_t      out_d;
    alu_out_t      out_q;

    assign op_e  = alu_op_e'(op_i);
    assign sub_w = needs_sub(op_e);

    alu_opnd #(.DW(DW), .IMMW(IMMW)) u_opnd (
        .op   (op_e),
        .opb  (opb_i),
        .imm  (imm_i),
        .opnd (opnd2)
    );

    alu_arith #(.DW(DW)) u_arith (
        .a      (opa_i),
        .b      (opnd2),
        .sub_en (sub_w),
        .sum    (sum_w),
        .lt_s   (lt_s_w),
        .lt_u   (lt_u_w)
    );

    alu_bitlog #(.DW(DW), .IMMW(IMMW), .SHW(SHW)) u_bitlog (
        .op    (op_e),
        .a     (opa_i),
        .b     (opnd2),
        .shamt (shamt_i),
        .imm   (imm_i),
        .res   (bl_w)
    );

    always_comb begin
        out_d = '0;
        unique case (op_e)
            OP_ADD, OP_SUB, OP_ADDI: out_d.res = sum_w;
            OP_SLT, OP_SLTI:         out_d.res = {{(DW-1){1'b0}}, lt_s_w};
            OP_SLTU, OP_SLTIU:       out_d.res = {{(DW-1){1'b0}}, lt_u_w};
            OP_AND, OP_OR, OP_NOR, OP_SLL, OP_SRL,
            OP_ANDI, OP_ORI, OP_LUI: out_d.res = bl_w;
            default:                 out_d.res = '0;
        endcase
        out_d.zero = (out_d.res == '0);
    end

    generate
        if (REG_OUT) begin : g_reg
            always_ff @(posedge clk_i or negedge rst_ni) begin
                if (!rst_ni) begin
                    out_q.res  <= '0;
                    out_q.zero <= 1'b1;
                end else begin
                    out_q <= out_d;
                end
            end

            AST_SLT_NEG_FIRST: assert property (@(posedge clk_i) disable iff (!rst_ni)
                (op_e == OP_SLT && opa_i[DW-1] && !opb_i[DW-1]) |=> (res_o == {{(DW-1){1'b0}}, 1'b1})); // R4
            AST_CMP_ONE_BIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
                (op_e inside {OP_SLT, OP_SLTI, OP_SLTU, OP_SLTIU}) |=> (res_o[DW-1:1] == '0)); // R4
            AST_SLTU_NEG_BIG: assert property (@(posedge clk_i) disable iff (!rst_ni)
                (op_e == OP_SLTU && opa_i[DW-1] && !opb_i[DW-1]) |=> (res_o == '0)); // R5
            AST_SHIFT_FILL: assert property (@(posedge clk_i) disable iff (!rst_ni)
                (op_e == OP_SLL && shamt_i != '0) |=> (res_o[0] == 1'b0)); // R6
            AST_LUI_LOW_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
                (op_e == OP_LUI) |=> (res_o[DW-IMMW-1:0] == '0)); // R7
            AST_ZERO_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
                zero_o == (res_o == '0)); // R9
            AST_UNDEF_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
                (op_e == OP_RSV) |=> (res_o == '0 && zero_o)); // R10
        end else begin : g_comb
            assign out_q = out_d;
        end
    endgenerate

    assign res_o  = out_q.res;
    assign zero_o = out_q.zero;

endmodule

// File: tb/sim_int_alu.sv
module sim_int_alu;
    localparam int CLK_PERIOD = 10;

    logic        clk;
    logic        rst_n;
    logic [3:0]  op;
    logic [31:0] opa;
    logic [31:0] opb;
    logic [4:0]  shamt;
    logic [15:0] imm;
    logic [31:0] res;
    logic        zero;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 0;

    int_alu u0 (
        .clk_i   (clk),
        .rst_ni  (rst_n),
        .op_i    (op),
        .opa_i   (opa),
        .opb_i   (opb),
        .shamt_i (shamt),
        .imm_i   (imm),
        .res_o   (res),
        .zero_o  (zero)
    );

    initial clk = 1'b0;
    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(string tag, logic [31:0] got, logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    // Drive one operation at the falling edge, sample just after the next rising edge
    task automatic run_op(string tag, logic [3:0] o, logic [31:0] a, logic [31:0] b,
                          logic [4:0] sh, logic [15:0] im, logic [31:0] exp_res);
        @(negedge clk);
        op = o; opa = a; opb = b; shamt = sh; imm = im;
        @(posedge clk);
        #1;
        check(tag, res, exp_res);
        check({tag, " zero flag R9"}, {31'd0, zero}, {31'd0, exp_res == 32'd0});
    endtask

    task automatic t_reset;
        check("R11 reset result", res, 32'd0);
        check("R11 reset zero flag", {31'd0, zero}, 32'd1);
    endtask

    task automatic t_arith;
        run_op("R1 add",           4'd0, 32'd5,        32'd7,        5'd0, 16'h0, 32'd12);
        run_op("R1 add wrap",      4'd0, 32'hFFFFFFFF, 32'd1,        5'd0, 16'h0, 32'd0);
        run_op("R1 sub negative",  4'd1, 32'd3,        32'd5,        5'd0, 16'h0, 32'hFFFFFFFE);
        run_op("R1 sub wrap",      4'd1, 32'h80000000, 32'd1,        5'd0, 16'h0, 32'h7FFFFFFF);
    endtask

    task automatic t_logic;
        run_op("R2 and", 4'd2, 32'h00003C00, 32'h00000DC0, 5'd0, 16'h0, 32'h00000C00);
        run_op("R2 or",  4'd3, 32'h00003C00, 32'h00000DC0, 5'd0, 16'h0, 32'h00003DC0);
        run_op("R2 nor as not", 4'd4, 32'h00003C00, 32'd0, 5'd0, 16'h0, 32'hFFFFC3FF);
        run_op("R2 nor ones",   4'd4, 32'hFFFF0000, 32'h0000FFFF, 5'd0, 16'h0, 32'd0);
    endtask

    task automatic t_addi;
        run_op("R3 addi minus one", 4'd9, 32'd10, 32'hDEADBEEF, 5'd0, 16'hFFFF, 32'd9);
        run_op("R3 addi max pos",   4'd9, 32'd0,  32'd0,        5'd0, 16'h7FFF, 32'h00007FFF);
        run_op("R3 addi min neg",   4'd9, 32'd0,  32'd0,        5'd0, 16'h8000, 32'hFFFF8000);
    endtask

    task automatic t_compare;
        run_op("R4 slt neg vs zero",   4'd7,  32'hFFFFFFFF, 32'd0,        5'd0, 16'h0, 32'd1);
        run_op("R4 slt equal",         4'd7,  32'd5,        32'd5,        5'd0, 16'h0, 32'd0);
        run_op("R4 slt maxpos vs minneg", 4'd7, 32'h7FFFFFFF, 32'h80000000, 5'd0, 16'h0, 32'd0);
        run_op("R4 slti neg imm",      4'd10, 32'hFFFFFFFE, 32'd0,        5'd0, 16'hFFFF, 32'd1);
        run_op("R5 sltu big vs zero",  4'd8,  32'hFFFFFFFF, 32'd0,        5'd0, 16'h0, 32'd0);
        run_op("R5 sltu small",        4'd8,  32'd3,        32'd7,        5'd0, 16'h0, 32'd1);
        run_op("R5 sltu maxpos vs minneg", 4'd8, 32'h7FFFFFFF, 32'h80000000, 5'd0, 16'h0, 32'd1);
        run_op("R5 sltiu sext imm",    4'd11, 32'd5,        32'd0,        5'd0, 16'hFFFF, 32'd1);
    endtask

    task automatic t_shift;
        run_op("R6 sll by 31",   4'd5, 32'hFFFFFFFF, 32'd1,        5'd31, 16'h0, 32'h80000000);
        run_op("R6 srl by 31",   4'd6, 32'hFFFFFFFF, 32'h80000000, 5'd31, 16'h0, 32'd1);
        run_op("R6 srl zero fill", 4'd6, 32'd0,      32'hFFFFFFFF, 5'd4,  16'h0, 32'h0FFFFFFF);
        run_op("R6 sll by 0",    4'd5, 32'h12345678, 32'hA5A5A5A5, 5'd0,  16'h0, 32'hA5A5A5A5);
    endtask

    task automatic t_lui;
        run_op("R7 lui",         4'd14, 32'hFFFFFFFF, 32'hFFFFFFFF, 5'd0, 16'd61, 32'h003D0000);
        run_op("R8 ori after lui", 4'd13, 32'h003D0000, 32'hFFFFFFFF, 5'd0, 16'd2304, 32'h003D0900);
    endtask

    task automatic t_imm_logic;
        run_op("R8 andi zext", 4'd12, 32'hFFFFFFFF, 32'd0, 5'd0, 16'hFF00, 32'h0000FF00);
        run_op("R8 ori zext",  4'd13, 32'd0,        32'd0, 5'd0, 16'h8000, 32'h00008000);
    endtask

    task automatic t_undef;
        run_op("R10 undefined code", 4'd15, 32'h12345678, 32'h9ABCDEF0, 5'd7, 16'h1234, 32'd0);
    endtask

    task automatic t_latency;
        run_op("R11 setup", 4'd0, 32'd40, 32'd2, 5'd0, 16'h0, 32'd42);
        @(negedge clk);
        op = 4'd0; opa = 32'd1; opb = 32'd1;
        #1;
        check("R11 holds before edge", res, 32'd42);
        @(posedge clk);
        #1;
        check("R11 updates after edge", res, 32'd2);
    endtask

    initial begin
        rst_n = 1'b0;
        op = 4'd0; opa = '0; opb = '0; shamt = '0; imm = '0;
        repeat (3) @(posedge clk);
        #1;
        t_reset();
        @(negedge clk);
        rst_n = 1'b1;
        t_arith();
        t_logic();
        t_addi();
        t_compare();
        t_shift();
        t_lui();
        t_imm_logic();
        t_undef();
        t_latency();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 5000);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule